// File: doc/BRIEF.md
# Two-Pass Arbitration Message Sender

This block is the transmit half of a bus arbitration agent. It lets a module broadcast a short numeric message through the arbitration competition instead of competing for bus tenure. When the message request input is raised, the block blocks the module's ordinary bus requests. It then takes part in two arbitration cycles in a row. On the first it presents the all-ones competition word, which marks the cycle as a message cycle. On the second it presents the 9-bit code held in its transmit register. Larger codes carry higher priority. The all-ones code is kept for the power-fail message.

The arbitration phase arrives as a small encoded input. The outcome of each competition comes from an external distributed comparator as a won/lost flag. The block drives the competition number, a participation flag, a request-blocking flag, and the enables that update the master and round-robin bits. Tenure never changes hands on a message cycle, so those enables stay quiet during one. When the second pass is won, a transmitted flag is raised. It stays high until the requester withdraws its request, which forms a four-phase handshake. If either pass is lost, the block starts again from the first pass on the next arbitration cycle.

Top module: `msg_arb_sender`

## Requirements
- R1: During and after synchronous reset, comp_num, compete, req_block, msg_sent, upd_master_en and upd_rr_en are all 0.
- R2: A high msg_req seen while the block is idle sets req_block on the next clock. req_block stays high until the second pass is won, and then drops on the same clock that msg_sent rises.
- R3: On the first arbitration cycle that begins after a message is accepted, the block presents comp_num = 0x1FF with compete = 1.
- R4: After the first pass is won, the next arbitration cycle presents the transmit register value as comp_num with compete = 1.
- R5: Winning the second pass sets msg_sent on the clock after the result. msg_sent stays high while msg_req is high and goes low on the clock after msg_req is seen low. A msg_req raised again after that starts a new message.
- R6: Losing either pass leaves msg_sent low and keeps req_block high. The next arbitration cycle presents 0x1FF again.
- R7: upd_master_en and upd_rr_en stay 0 for every message cycle, whether it is won or lost.
- R8: With bus_req high and no message in progress, an arbitration cycle presents own_num, latched when the cycle begins. At its result, upd_rr_en pulses for one clock, and upd_master_en pulses together with it only if the cycle was won.
- R9: While a message is pending, bus_req is ignored. A cycle that begins then presents the message words, never own_num.
- R10: A msg_load pulse writes msg_din into the transmit register only while req_block is low. A load while req_block is high has no effect on the later second-pass word.
- R11: phase code 1 begins an arbitration cycle and code 3 delivers the result on arb_won. Only the first clock of each code acts, and outputs change on the clock after it. Holding code 1 does not reload comp_num, and compete and comp_num clear at the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 3 | Arbitration phase code (1 start, 3 result) |
| arb_won | input | 1 | Competition won, valid with phase code 3 |
| bus_req | input | 1 | Ordinary tenure request |
| own_num | input | 9 | Module arbitration number for ordinary cycles |
| msg_req | input | 1 | Message send request |
| msg_load | input | 1 | Write strobe for the transmit register |
| msg_din | input | 9 | Message code to load |
| comp_num | output | 9 | Competition number to present |
| compete | output | 1 | Block takes part in the current cycle |
| req_block | output | 1 | Ordinary requests are blocked by a pending message |
| msg_sent | output | 1 | Message transmitted, held until msg_req drops |
| upd_master_en | output | 1 | One-clock enable to update the master bit |
| upd_rr_en | output | 1 | One-clock enable to update the round-robin bit |

## Verification
The hardest state to reach is a second pass lost after a first pass that was won, with a load attempt already made while the request was pending. Reaching it takes a chain of phase sequences with the won flag chosen separately for each result. The stimulus scripts that chain directly. It wins the first pass, writes a new code during the blocked window, loses the second pass, and then wins both passes. The final second-pass word must still be the code loaded before the request.

// File: rtl/msgarb_pkg.sv
package msgarb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_NORM, ST_PEND, ST_P1, ST_P2W, ST_P2, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_ALL1, SEL_MSG, SEL_OWN
  } word_sel_t;
endpackage

// File: rtl/phase_tracker.sv
module phase_tracker #(
  parameter int PH_W      = 3,
  parameter int PH_START  = 1,
  parameter int PH_RESULT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase,
  output logic            start_evt,
  output logic            res_evt
);
  localparam logic [PH_W-1:0] CODE_START  = PH_W'(PH_START);
  localparam logic [PH_W-1:0] CODE_RESULT = PH_W'(PH_RESULT);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= phase;
  end

  // act only on the first clock of each code
  assign start_evt = (phase == CODE_START)  && (ph_q != CODE_START);
  assign res_evt   = (phase == CODE_RESULT) && (ph_q != CODE_RESULT);
endmodule

// File: rtl/txmsg_reg.sv
module txmsg_reg #(
  parameter int NUM_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] din,
  input  logic             lock,
  output logic [NUM_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (load && !lock) q <= din;
  end
endmodule

// File: rtl/msg_seq.sv
module msg_seq
  import msgarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      msg_req,
  input  logic      bus_req,
  input  logic      start_evt,
  input  logic      res_evt,
  input  logic      arb_won,
  output word_sel_t sel,
  output logic      req_block,
  output logic      msg_sent,
  output logic      upd_master,
  output logic      upd_rr
);
  seq_state_t st_q, st_d;
  logic       um_d, urr_d;

  always_comb begin
    st_d  = st_q;
    sel   = SEL_NONE;
    um_d  = 1'b0;
    urr_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (msg_req) begin
          st_d = ST_PEND;
        end else if (start_evt && bus_req) begin
          st_d = ST_NORM;
          sel  = SEL_OWN;
        end
      end
      ST_NORM: begin
        if (res_evt) begin
          st_d  = ST_IDLE;
          urr_d = 1'b1;
          um_d  = arb_won;
        end
      end
      ST_PEND: begin
        if (start_evt) begin
          st_d = ST_P1;
          sel  = SEL_ALL1;
        end
      end
      ST_P1: begin
        if (res_evt) st_d = arb_won ? ST_P2W : ST_PEND;
      end
      ST_P2W: begin
        if (start_evt) begin
          st_d = ST_P2;
          sel  = SEL_MSG;
        end
      end
      ST_P2: begin
        if (res_evt) st_d = arb_won ? ST_DONE : ST_PEND;
      end
      ST_DONE: begin
        if (!msg_req) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      req_block  <= 1'b0;
      msg_sent   <= 1'b0;
      upd_master <= 1'b0;
      upd_rr     <= 1'b0;
    end else begin
      st_q       <= st_d;
      req_block  <= (st_d == ST_PEND) || (st_d == ST_P1) ||
                    (st_d == ST_P2W)  || (st_d == ST_P2);
      msg_sent   <= (st_d == ST_DONE);
      upd_master <= um_d;
      upd_rr     <= urr_d;
    end
  end
endmodule

// File: rtl/comp_word.sv
module comp_word
  import msgarb_pkg::*;
#(
  parameter int NUM_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  word_sel_t        sel,
  input  logic             clear,
  input  logic [NUM_W-1:0] txmsg,
  input  logic [NUM_W-1:0] own_num,
  output logic [NUM_W-1:0] comp_num,
  output logic             compete
);
  localparam logic [NUM_W-1:0] MARK_WORD = {NUM_W{1'b1}};

  logic [NUM_W-1:0] word_d;

  always_comb begin
    unique case (sel)
      SEL_ALL1: word_d = MARK_WORD;
      SEL_MSG:  word_d = txmsg;
      SEL_OWN:  word_d = own_num;
      default:  word_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      comp_num <= '0;
      compete  <= 1'b0;
    end else if (sel != SEL_NONE) begin
      comp_num <= word_d;
      compete  <= 1'b1;
    end
  end
endmodule

// File: rtl/msg_arb_sender.sv
module msg_arb_sender
  import msgarb_pkg::*;
#(
  parameter int NUM_W     = 9,
  parameter int PH_W      = 3,
  parameter int PH_START  = 1,
  parameter int PH_RESULT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase,
  input  logic             arb_won,
  input  logic             bus_req,
  input  logic [NUM_W-1:0] own_num,
  input  logic             msg_req,
  input  logic             msg_load,
  input  logic [NUM_W-1:0] msg_din,
  output logic [NUM_W-1:0] comp_num,
  output logic             compete,
  output logic             req_block,
  output logic             msg_sent,
  output logic             upd_master_en,
  output logic             upd_rr_en
);
  logic             start_evt, res_evt;
  logic [NUM_W-1:0] txmsg_q;
  word_sel_t        sel;

  phase_tracker #(.PH_W(PH_W), .PH_START(PH_START), .PH_RESULT(PH_RESULT)) ph_i (
    .clk(clk), .rst(rst), .phase(phase),
    .start_evt(start_evt), .res_evt(res_evt)
  );

  txmsg_reg #(.NUM_W(NUM_W)) tx_i (
    .clk(clk), .rst(rst), .load(msg_load), .din(msg_din),
    .lock(req_block), .q(txmsg_q)
  );

  msg_seq seq_i (
    .clk(clk), .rst(rst), .msg_req(msg_req), .bus_req(bus_req),
    .start_evt(start_evt), .res_evt(res_evt), .arb_won(arb_won),
    .sel(sel), .req_block(req_block), .msg_sent(msg_sent),
    .upd_master(upd_master_en), .upd_rr(upd_rr_en)
  );

  comp_word #(.NUM_W(NUM_W)) word_i (
    .clk(clk), .rst(rst), .sel(sel), .clear(res_evt),
    .txmsg(txmsg_q), .own_num(own_num),
    .comp_num(comp_num), .compete(compete)
  );
endmodule

// File: rtl/msg_arb_sender_chk.sv
module msg_arb_sender_chk #(
  parameter int NUM_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_req,
  input logic [NUM_W-1:0] comp_num,
  input logic             compete,
  input logic             req_block,
  input logic             msg_sent,
  input logic             upd_master_en,
  input logic             upd_rr_en,
  input logic [NUM_W-1:0] txmsg
);
  // R1
  idle_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !compete |-> (comp_num == '0));

  // R2
  sent_unblocks_chk: assert property (@(posedge clk) disable iff (rst)
    msg_sent |-> !req_block);

  // R5
  sent_held_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_sent && msg_req) |=> msg_sent);

  // R7
  blocked_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    req_block |-> (!upd_master_en && !upd_rr_en));

  // R7
  sent_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_sent) |-> (!upd_master_en && !upd_rr_en));

  // R9
  msg_word_only_chk: assert property (@(posedge clk) disable iff (rst)
    (compete && req_block) |-> (comp_num == {NUM_W{1'b1}} || comp_num == txmsg));
endmodule

bind msg_arb_sender msg_arb_sender_chk #(.NUM_W(NUM_W)) chk_i (
  .clk(clk), .rst(rst), .msg_req(msg_req), .comp_num(comp_num),
  .compete(compete), .req_block(req_block), .msg_sent(msg_sent),
  .upd_master_en(upd_master_en), .upd_rr_en(upd_rr_en), .txmsg(txmsg_q)
);

// File: tb/msg_arb_sender_tb.sv
module msg_arb_sender_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    phase = '0;
  logic          arb_won = 1'b0;
  logic          bus_req = 1'b0;
  logic [NW-1:0] own_num = 9'h055;
  logic          msg_req = 1'b0;
  logic          msg_load = 1'b0;
  logic [NW-1:0] msg_din = '0;
  logic [NW-1:0] comp_num;
  logic          compete, req_block, msg_sent, upd_master_en, upd_rr_en;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  bit finished = 1'b0;

  typedef struct {
    int            cyc;
    logic [NW-1:0] comp;
    logic          cmp, blk, snt, um, urr;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  msg_arb_sender dut_i (
    .clk(clk), .rst(rst), .phase(phase), .arb_won(arb_won), .bus_req(bus_req),
    .own_num(own_num), .msg_req(msg_req), .msg_load(msg_load), .msg_din(msg_din),
    .comp_num(comp_num), .compete(compete), .req_block(req_block),
    .msg_sent(msg_sent), .upd_master_en(upd_master_en), .upd_rr_en(upd_rr_en)
  );

  // monitor: pop expectations due this cycle and compare
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].cyc == cyc_cnt) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (comp_num !== e.comp || compete !== e.cmp || req_block !== e.blk ||
            msg_sent !== e.snt || upd_master_en !== e.um || upd_rr_en !== e.urr) begin
          errors++;
          $display("FAIL %s: actual comp=%h cmp=%b blk=%b sent=%b um=%b urr=%b expected comp=%h cmp=%b blk=%b sent=%b um=%b urr=%b",
                   e.tag, comp_num, compete, req_block, msg_sent, upd_master_en, upd_rr_en,
                   e.comp, e.cmp, e.blk, e.snt, e.um, e.urr);
        end
      end
    end
  end

  // driver: apply inputs for one clock, queue the outputs due after it
  task automatic step(input logic [2:0] ph, input logic won, input logic br,
                      input logic mr, input logic [NW-1:0] e_comp, input logic e_cmp,
                      input logic e_blk, input logic e_snt, input logic e_um,
                      input logic e_urr, input string tag);
    exp_t e;
    phase   = ph;
    arb_won = won;
    bus_req = br;
    msg_req = mr;
    e.cyc = cyc_cnt + 1;
    e.comp = e_comp; e.cmp = e_cmp; e.blk = e_blk; e.snt = e_snt;
    e.um = e_um; e.urr = e_urr; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    msg_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R1 reset state");
    // ordinary cycle won, then lost
    step(1, 0, 1, 0, 9'h055, 1, 0, 0, 0, 0, "R8 own number presented");
    step(2, 0, 1, 0, 9'h055, 1, 0, 0, 0, 0, "R8 held in phase 2");
    step(3, 1, 1, 0, 9'h000, 0, 0, 0, 1, 1, "R8 won updates master and rr");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R8 update is one clock");
    step(1, 0, 1, 0, 9'h055, 1, 0, 0, 0, 0, "R8 second ordinary cycle");
    step(3, 0, 1, 0, 9'h000, 0, 0, 0, 0, 1, "R8 lost updates rr only");
    // entry-only phase action and latched own number
    step(1, 0, 1, 0, 9'h055, 1, 0, 0, 0, 0, "R11 start entry");
    own_num = 9'h077;
    step(1, 0, 1, 0, 9'h055, 1, 0, 0, 0, 0, "R11 held code 1 does not reload");
    step(3, 0, 0, 0, 9'h000, 0, 0, 0, 0, 1, "R11 result clears word");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R11 idle");
    // load first message while idle
    msg_load = 1'b1; msg_din = 9'h0A5;
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R10 idle load");
    // message with bus_req also high: message has the bus
    step(0, 0, 1, 1, 9'h000, 0, 1, 0, 0, 0, "R2 request blocks");
    step(1, 0, 1, 1, 9'h1FF, 1, 1, 0, 0, 0, "R3 first pass all ones, R9 bus_req ignored");
    step(2, 0, 1, 1, 9'h1FF, 1, 1, 0, 0, 0, "R3 first pass held");
    step(3, 1, 1, 1, 9'h000, 0, 1, 0, 0, 0, "R7 first pass won no update");
    msg_load = 1'b1; msg_din = 9'h111;
    step(0, 0, 1, 1, 9'h000, 0, 1, 0, 0, 0, "R10 load while blocked");
    step(1, 0, 1, 1, 9'h0A5, 1, 1, 0, 0, 0, "R4 second pass message word");
    step(3, 0, 1, 1, 9'h000, 0, 1, 0, 0, 0, "R6 second pass lost stays pending");
    step(1, 0, 1, 1, 9'h1FF, 1, 1, 0, 0, 0, "R6 retry from first pass");
    step(3, 1, 1, 1, 9'h000, 0, 1, 0, 0, 0, "R6 retry first pass won");
    step(1, 0, 1, 1, 9'h0A5, 1, 1, 0, 0, 0, "R10 blocked load had no effect");
    step(3, 1, 1, 1, 9'h000, 0, 0, 1, 0, 0, "R5 sent, R7 no update, R2 unblocked");
    step(0, 0, 0, 1, 9'h000, 0, 0, 1, 0, 0, "R5 sent held with request");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R5 sent released");
    step(0, 0, 0, 1, 9'h000, 0, 1, 0, 0, 0, "R5 request evaluated again");
    step(1, 0, 0, 1, 9'h1FF, 1, 1, 0, 0, 0, "R3 new message first pass");
    step(3, 0, 0, 1, 9'h000, 0, 1, 0, 0, 0, "R6 first pass lost");
    step(1, 0, 0, 1, 9'h1FF, 1, 1, 0, 0, 0, "R6 first pass repeated");
    step(3, 1, 0, 1, 9'h000, 0, 1, 0, 0, 0, "R7 won first pass");
    step(1, 0, 0, 1, 9'h0A5, 1, 1, 0, 0, 0, "R4 second pass");
    step(3, 1, 0, 1, 9'h000, 0, 0, 1, 0, 0, "R5 second message sent");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R5 handshake done");
    // new code loaded while idle is used
    msg_load = 1'b1; msg_din = 9'h1C3;
    step(0, 0, 0, 1, 9'h000, 0, 1, 0, 0, 0, "R10 load with request same clock");
    step(1, 0, 0, 1, 9'h1FF, 1, 1, 0, 0, 0, "R3 first pass");
    step(3, 1, 0, 1, 9'h000, 0, 1, 0, 0, 0, "R7 first pass won");
    step(1, 0, 0, 1, 9'h1C3, 1, 1, 0, 0, 0, "R10 new code sent");
    step(3, 1, 0, 1, 9'h000, 0, 0, 1, 0, 0, "R5 sent");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R5 released");
    step(1, 0, 1, 0, 9'h077, 1, 0, 0, 0, 0, "R8 ordinary cycle resumes");
    step(3, 1, 0, 0, 9'h000, 0, 0, 0, 1, 1, "R8 won after messages");
    step(0, 0, 0, 0, 9'h000, 0, 0, 0, 0, 0, "R8 quiet");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule